// File: doc/BRIEF.md
# MDIO Management Master

This block lets a processor on a 32-bit register bus reach external Ethernet PHYs over the two-wire management interface. Software writes one command word that holds the operation, the PHY address, the register address and the write data. The controller takes the command into a single-entry slot, builds a Clause 22 frame and shifts it out on MDIO, timed by an MDC clock divided down from the system clock.

Two status flags show progress. "Pending" means a command sits in the slot and the frame engine has not yet taken it. "Busy" means a command is pending or a frame is on the wire. When a read finishes, the 16 bits returned by the PHY go into a result register, together with a two-bit error field. The error field is set when the PHY does not pull the line low during turnaround.

The bus has a byte address and a write strobe. Reads are combinational: `bus_rdata` follows `bus_addr` in the same cycle. The MDIO pad is split into an output, an output enable and an input, so the tristate buffer and the pull-up sit outside the block.

Top module: `mdio_master`

## Requirements
- R1: After reset the status word reads 0, the result register reads 0, MDC is low and the MDIO output enable is low.
- R2: A bus write to offset 0x8 is accepted when bit 31 is set and bit 1 (write) or bit 2 (read) is set, with bit 2 taking priority. Bits 29:25 carry the PHY address, bits 24:20 the register address and bits 19:4 the write data. In the cycle after acceptance, status offset 0x0 shows bit 2 (pending) and bit 3 (busy) both set, and every other status bit stays 0.
- R3: A command word is ignored, leaving status and the queued command unchanged, in three cases: bit 31 is clear, neither op bit is set, or pending is already set.
- R4: Pending clears one cycle after acceptance when no frame is running. Otherwise it stays set until the running frame ends, and clears one cycle after that.
- R5: MDC is low whenever no frame is running. During a frame it has a period of 2*DIV_HALF system cycles. The first rising edge comes DIV_HALF cycles after the frame starts, and each frame has exactly 64 MDC periods.
- R6: Each frame is sent MSB first as follows: 32 ones, start bits 01, opcode (10 for a read, 01 for a write), the 5-bit PHY address, the 5-bit register address, then turnaround 10 and the 16 data bits for a write.
- R7: The MDIO output changes only when MDC falls or when a frame starts, and never while MDC stays high.
- R8: For a read, the output enable is low from bit 46 (the first turnaround bit) through bit 63. For a write, it stays high for all 64 bits. It is low when idle.
- R9: Offset 0xC reads {14'b0, err, err, data}. The data field holds the line values sampled on the MDC rising edges of bits 48..63, MSB first. Err is 1 if the line was high at the rising edge of bit 47.
- R10: Busy clears on the system clock edge where MDC falls at the end of bit 63. The result register keeps its previous value until that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_o | output | 1 | Management data driven by the block |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data seen on the line |

## Verification
The hardest case to reach is a command accepted while a frame is already on the wire. Pending must then stay set for the whole remaining frame and be taken exactly one cycle after the old frame ends. The stimulus gets there by waiting on the reference model until the engine has taken a first command and cleared pending, then writing a second one mid-frame. The second hard case is a read whose turnaround bit is left high. A behavioural PHY in the bench drives the line from the model's bit position, so it can release the turnaround bit on demand. It also returns chosen data bits, so the result register and its error field can be checked before and after the end of the frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int BUS_W      = 32;
    localparam int PHY_W      = 5;
    localparam int REG_W      = 5;
    localparam int DAT_W      = 16;
    localparam int FRAME_BITS = 64;
    localparam int PRE_BITS   = 32;
    localparam int TA_IDX     = 46;
    localparam int DATA_IDX   = 48;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    localparam int OFF_STAT   = 'h0;
    localparam int OFF_CMD    = 'h8;
    localparam int OFF_RES    = 'hC;

    localparam int CMD_GO     = 31;
    localparam int CMD_PHY_LO = 25;
    localparam int CMD_REG_LO = 20;
    localparam int CMD_DAT_LO = 4;
    localparam int CMD_RD     = 2;
    localparam int CMD_WR     = 1;

    localparam int ST_PEND    = 2;
    localparam int ST_BUSY    = 3;

    typedef struct packed {
        logic             rd;
        logic [PHY_W-1:0] phy;
        logic [REG_W-1:0] regad;
        logic [DAT_W-1:0] wdata;
    } mdio_cmd_t;

    typedef struct packed {
        logic             err;
        logic [DAT_W-1:0] data;
    } mdio_res_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
        logic [1:0]       op;
        logic [1:0]       ta;
        logic [DAT_W-1:0] body;
        op   = c.rd ? 2'b10 : 2'b01;
        ta   = c.rd ? 2'b11 : 2'b10;
        body = c.rd ? {DAT_W{1'b1}} : c.wdata;
        return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regad, ta, body};
    endfunction

    function automatic mdio_cmd_t decode_cmd(input logic [BUS_W-1:0] w);
        mdio_cmd_t c;
        c.rd    = w[CMD_RD];
        c.phy   = w[CMD_PHY_LO +: PHY_W];
        c.regad = w[CMD_REG_LO +: REG_W];
        c.wdata = w[CMD_DAT_LO +: DAT_W];
        return c;
    endfunction

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap = en && (cnt == LAST);
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pending,
    input  mdio_cmd_t cmd,
    input  logic      rise,
    input  logic      fall,
    input  logic      mdio_i,
    output logic      take,
    output logic      active,
    output logic      mdio_o,
    output logic      mdio_oe,
    output mdio_res_t res
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(TA_IDX + 1);
    localparam logic [IDX_W-1:0] TA1_IDX  = IDX_W'(TA_IDX);
    localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DATA_IDX);

    logic [FRAME_BITS-1:0] shreg;
    logic [IDX_W-1:0]      idx;
    logic                  rd_q;
    logic                  err_q;
    logic [DAT_W-1:0]      rx;

    assign take    = pending && !active;
    assign mdio_o  = active && shreg[FRAME_BITS-1];
    assign mdio_oe = active && !(rd_q && (idx >= TA1_IDX));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            shreg  <= '0;
            idx    <= '0;
            rd_q   <= 1'b0;
            err_q  <= 1'b0;
            rx     <= '0;
            res    <= '0;
        end else if (take) begin
            active <= 1'b1;
            shreg  <= build_frame(cmd);
            idx    <= '0;
            rd_q   <= cmd.rd;
            err_q  <= 1'b0;
        end else if (active) begin
            if (rise && rd_q) begin
                if (idx == TA2_IDX)
                    err_q <= mdio_i;
                else if (idx >= DAT_IDX)
                    rx <= {rx[DAT_W-2:0], mdio_i};
            end
            if (fall) begin
                if (idx == LAST_IDX) begin
                    active <= 1'b0;
                    if (rd_q) begin
                        res.err  <= err_q;
                        res.data <= rx;
                    end
                end else begin
                    idx   <= idx + 1'b1;
                    shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              take,
    input  logic              active,
    input  mdio_res_t         res,
    output logic              pending,
    output mdio_cmd_t         cmd
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_RES  = ADDR_W'(OFF_RES);

    logic accept;
    logic busy;

    assign accept = bus_we && (bus_addr == A_CMD) && bus_wdata[CMD_GO]
                  && (bus_wdata[CMD_RD] || bus_wdata[CMD_WR]) && !pending;
    assign busy   = pending || active;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            cmd     <= '0;
        end else if (accept) begin
            pending <= 1'b1;
            cmd     <= decode_cmd(bus_wdata);
        end else if (take) begin
            pending <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_STAT: begin
                bus_rdata[ST_PEND] = pending;
                bus_rdata[ST_BUSY] = busy;
            end
            A_RES: bus_rdata[DAT_W+1:0] = {res.err, res.err, res.data};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_HALF = 2,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic      pending;
    logic      take;
    logic      eng_active;
    logic      tick_rise;
    logic      tick_fall;
    mdio_cmd_t cmd;
    mdio_res_t res;

    mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .take     (take),
        .active   (eng_active),
        .res      (res),
        .pending  (pending),
        .cmd      (cmd)
    );

    mdio_clkdiv #(.DIV_HALF(DIV_HALF)) u_div (
        .clk (clk),
        .rst (rst),
        .en  (eng_active),
        .mdc (mdc),
        .rise(tick_rise),
        .fall(tick_fall)
    );

    mdio_engine u_eng (
        .clk    (clk),
        .rst    (rst),
        .pending(pending),
        .cmd    (cmd),
        .rise   (tick_rise),
        .fall   (tick_fall),
        .mdio_i (mdio_i),
        .take   (take),
        .active (eng_active),
        .mdio_o (mdio_o),
        .mdio_oe(mdio_oe),
        .res    (res)
    );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic              mdc,
    input logic              mdio_o,
    input logic              pending,
    input logic              active,
    input mdio_cmd_t         cmd
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pending && !active && !mdc));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == ADDR_W'(OFF_CMD) && bus_wdata[31]
         && (bus_wdata[2] || bus_wdata[1]) && !pending) |=> pending);

    // R3
    held_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && $past(pending)) |-> $stable(cmd));

    // R4
    take_chk: assert property (@(posedge clk) disable iff (rst)
        (pending && !active) |=> (!pending && active));

    // R5
    idle_mdc_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> !mdc);

    // R7
    mdo_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> $stable(mdio_o));
endmodule

bind mdio_master mdio_master_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .pending  (pending),
    .active   (eng_active),
    .cmd      (cmd)
);

// File: tb/mdio_master_tb.sv
module mdio_master_tb;
    localparam int H = 2;
    localparam int FRAME_CYC = 128 * H;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 0;

    // behavioural reference state
    bit          m_pend, m_act, m_rd, m_qrd;
    int          m_j;
    logic [63:0] m_frame;
    logic [4:0]  m_qphy, m_qreg;
    logic [15:0] m_qdat;
    logic [31:0] m_res;
    bit          m_take, m_acc;
    // PHY stimulus
    logic [15:0] phy_val = 16'h0;
    bit          phy_bad_ta = 0;

    always #10 clk = ~clk;

    mdio_master #(.DIV_HALF(H), .ADDR_W(4)) u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    function automatic logic [63:0] ref_frame(bit rd, logic [4:0] p, logic [4:0] r, logic [15:0] d);
        logic [63:0] f;
        f = '1;
        f[31:30] = 2'b01;
        f[29:28] = rd ? 2'b10 : 2'b01;
        f[27:23] = p;
        f[22:18] = r;
        if (!rd) begin
            f[17:16] = 2'b10;
            f[15:0]  = d;
        end
        return f;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_pend = 0; m_act = 0; m_rd = 0; m_j = 0; m_frame = '0; m_res = '0;
            m_qrd = 0; m_qphy = '0; m_qreg = '0; m_qdat = '0;
        end else begin
            m_take = m_pend && !m_act;
            m_acc  = bus_we && bus_addr == 4'h8 && bus_wdata[31]
                     && (bus_wdata[2] || bus_wdata[1]) && !m_pend;
            if (m_act) begin
                if (m_j == FRAME_CYC - 1) begin
                    m_act = 0;
                    if (m_rd) m_res = {14'b0, {2{phy_bad_ta}}, phy_val};
                end else m_j++;
            end
            if (m_take) begin
                m_act = 1; m_j = 0; m_rd = m_qrd;
                m_frame = ref_frame(m_qrd, m_qphy, m_qreg, m_qdat);
            end
            if (m_acc) begin
                m_pend = 1;
                m_qrd = bus_wdata[2]; m_qphy = bus_wdata[29:25];
                m_qreg = bus_wdata[24:20]; m_qdat = bus_wdata[19:4];
            end else if (m_take) m_pend = 0;
        end
    end

    // per-cycle comparison against the model, a quarter period after the edge
    always @(posedge clk) begin
        #5;
        if (!rst && !finished) begin
            int k;
            bit e_oe;
            k = m_j / (2 * H);
            check("R5 mdc", {31'b0, mdc}, {31'b0, m_act && ((m_j / H) % 2 == 1)});
            e_oe = m_act && !(m_rd && k >= 46);
            check("R8 oe", {31'b0, mdio_oe}, {31'b0, e_oe});
            if (e_oe) check("R6 bit", {31'b0, mdio_o}, {31'b0, m_frame[63-k]});
            if (bus_addr == 4'h0 && !bus_we) begin
                check("R4 pending", {31'b0, bus_rdata[2]}, {31'b0, m_pend});
                check("R10 busy", {31'b0, bus_rdata[3]}, {31'b0, m_pend || m_act});
                check("R2 status spare bits", bus_rdata & ~32'hC, 32'h0);
            end
        end
    end

    // PHY model drives the line from the model's bit position
    always @(negedge clk) begin
        int k;
        k = m_j / (2 * H);
        if (m_act && m_rd && k == 47) mdio_i <= phy_bad_ta;
        else if (m_act && m_rd && k >= 48) mdio_i <= phy_val[63-k];
        else mdio_i <= 1'b1;
    end

    task automatic send(bit v, logic [1:0] op, logic [4:0] p, logic [4:0] r, logic [15:0] d);
        @(negedge clk);
        bus_addr  = 4'h8;
        bus_we    = 1'b1;
        bus_wdata = {v, 1'b0, p, r, d, 1'b0, op, 1'b0};
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = 4'h0;
    endtask

    task automatic wait_idle();
        while (m_pend || m_act) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic read_reg(logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        @(posedge clk);
        #5 v = bus_rdata;
        @(negedge clk);
        bus_addr = 4'h0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        read_reg(4'h0, v); check("R1 status", v, 32'h0);
        read_reg(4'hC, v); check("R1 result", v, 32'h0);
        check("R1 mdc/oe", {30'b0, mdc, mdio_oe}, 32'h0);

        // R6 plain write
        send(1, 2'b01, 5'h05, 5'h1A, 16'hA55A);
        wait_idle();

        // R9 good read
        phy_val = 16'h3C96; phy_bad_ta = 0;
        send(1, 2'b10, 5'h1F, 5'h03, 16'h0);
        wait_idle();
        read_reg(4'hC, v); check("R9 read data", v, 32'h0000_3C96);

        // R10 result held mid-frame, R9 error on bad turnaround
        phy_val = 16'h1234; phy_bad_ta = 1;
        send(1, 2'b10, 5'h01, 5'h11, 16'h0);
        repeat (100) @(negedge clk);
        read_reg(4'hC, v); check("R10 result held", v, 32'h0000_3C96);
        wait_idle();
        read_reg(4'hC, v); check("R9 error flag", v, 32'h0003_1234);
        phy_bad_ta = 0;

        // R3 ignored commands
        send(0, 2'b01, 5'h02, 5'h02, 16'hFFFF);
        read_reg(4'h0, v); check("R3 no valid bit", v, 32'h0);
        send(1, 2'b00, 5'h02, 5'h02, 16'hFFFF);
        read_reg(4'h0, v); check("R3 no op bit", v, 32'h0);

        // R3 second command while pending is dropped
        @(negedge clk);
        bus_addr = 4'h8; bus_we = 1'b1;
        bus_wdata = {1'b1, 1'b0, 5'h0A, 5'h0B, 16'h00FF, 4'b0010};
        @(negedge clk);
        bus_wdata = {1'b1, 1'b0, 5'h15, 5'h16, 16'hFF00, 4'b0010};
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 4'h0;
        wait_idle();

        // R4 queue behind a running frame
        send(1, 2'b01, 5'h00, 5'h00, 16'h0000);
        while (!(m_act && !m_pend)) @(negedge clk);
        repeat (20) @(negedge clk);
        phy_val = 16'hBEEF;
        send(1, 2'b10, 5'h1F, 5'h1F, 16'h0);
        read_reg(4'h0, v); check("R4 queued pending", v, 32'h0000_000C);
        wait_idle();
        read_reg(4'hC, v); check("R9 queued read", v, 32'h0000_BEEF);

        // R2 both op bits: read wins
        phy_val = 16'h8001;
        send(1, 2'b11, 5'h11, 5'h07, 16'h5555);
        read_reg(4'h0, v); check("R2 accepted", v, 32'h0000_0008);
        wait_idle();
        read_reg(4'hC, v); check("R2 read priority", v, 32'h0000_8001);
        read_reg(4'h8, v); check("R2 command offset reads zero", v, 32'h0);

        finish_run();
    end
endmodule